// File: doc/BRIEF.md
# Endian Lane Steering Unit

This unit sits between a load/store pipeline and a memory port that is eight bytes wide. For every access it moves bytes between memory lanes and value bytes, so that 1-, 2-, 4- and 8-byte accesses return or write the right value under the selected byte ordering. It supports three kinds of ordering:

- little-endian;
- big-endian with the byte address preserved;
- big-endian with the value of a datum preserved, where the datum (granule) is 2, 4 or 8 bytes.

A load gives back a zero-extended value. A store gives the data as seen from memory, with a byte-enable mask. Both come out of a single output register stage, one cycle after the request.

Steering is done by first computing a physical start lane and a reverse flag for the request. The datapath then shifts by the start lane and, when the flag is set, reverses the bytes inside the access. A request whose offset is not a multiple of its size is flagged as an error and touches no lanes. The ordering select is sampled with each request, so a change applies from the next access on.

Top module: `lane_steer`

## Requirements
- R1: Memory byte at offset k is carried on memRdata/wrData bits [8k+7:8k]. Size code n means an access of 2^n bytes. In mode 0 (little-endian), an aligned load at offset A of S bytes returns the bytes at A..A+S-1, with the byte at A least significant and the upper result bytes zero.
- R2: In mode 1 (big-endian, address preserved), a load reads the same bytes as in R1, but the byte at A is the most significant. A 1-byte load returns the same byte as in mode 0.
- R3: Modes 2, 3 and 4 are big-endian with the datum value preserved, with granule G of 2, 4 and 8 bytes respectively. In these modes, an access with S >= G behaves exactly as in mode 0.
- R4: In modes 2 to 4, an access with S < G uses the physical start address A XOR (G-S) and assembles the value little-endian. For memory 0x99887766ddccbbaa, this gives:
  - mode 3, 1-byte load at 0: 0xdd;
  - mode 3, 2-byte load at 0: 0xddcc;
  - mode 2, 1-byte load at 0: 0xbb;
  - mode 4, 4-byte load at 0: 0x99887766.
- R5: An aligned store places store-data byte i on the memory lane that the equal load would read as value byte i. All other lanes of wrData are zero, and ldData reads zero.
- R6: wrBe has a one for each lane written by an aligned store, which is exactly S contiguous lanes. Loads give wrBe of zero.
- R7: When the offset is not a multiple of S, rspErr is 1 and wrBe, wrData and ldData are all zero.
- R8: rspValid is 1 exactly one cycle after reqValid. The result fields hold their last values while no request arrives. Each request uses the mode present with it, so a mode change applies from the next access.
- R9: In reset, all outputs are zero.
- R10: Mode codes 5 to 7 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reqValid | input | 1 | access request this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqOffset | input | 3 | byte offset inside the 8-byte word |
| reqSize | input | 2 | size code, 2^n bytes |
| reqMode | input | 3 | byte-ordering mode code |
| memRdata | input | 64 | memory word for loads |
| stData | input | 64 | store value, right-aligned |
| rspValid | output | 1 | result valid |
| rspErr | output | 1 | misaligned access |
| ldData | output | 64 | zero-extended load value |
| wrData | output | 64 | memory-side store data |
| wrBe | output | 8 | store byte enables |

## Verification
The assertions assume that reqStore and reqSize are stable in the cycle of a request, and that they are compared one cycle later through $past. This relies on the bench driving every request field together on the falling edge. The assertions also assume that reqValid is low throughout reset. The bench sweeps every mode, including one reserved code, together with every size, every offset and both directions, using two distinct data patterns. Misaligned offsets therefore fall naturally inside the sweep, and the expected lane map is derived from the granule arithmetic.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  parameter int unsigned LANES = 8;
  parameter int unsigned OFF_W = $clog2(LANES);
  parameter int unsigned SZ_W  = $clog2(OFF_W + 1);
  parameter int unsigned DW    = LANES * 8;

  typedef enum logic [2:0] {
    MODE_LE      = 3'd0,
    MODE_BE_ADDR = 3'd1,
    MODE_BE_DI16 = 3'd2,
    MODE_BE_DI32 = 3'd3,
    MODE_BE_DI64 = 3'd4
  } endian_mode_e;

  typedef struct packed {
    logic             fire;
    logic             isStore;
    logic             misalign;
    logic             reverse;
    logic [OFF_W-1:0] physOff;
    logic [OFF_W-1:0] lastIdx;
    logic [LANES-1:0] keep;
    logic [LANES-1:0] laneEn;
  } steer_ctrl_t;
endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import lane_steer_pkg::*;
(
  input  logic             reqValid,
  input  logic             reqStore,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [SZ_W-1:0]  reqSize,
  input  logic [2:0]       reqMode,
  output steer_ctrl_t      ctrl
);
  logic [OFF_W:0]   accBytes;
  logic [OFF_W:0]   gBytes;
  logic [OFF_W-1:0] sizeMask;
  logic             aligned;
  logic             diMode;
  logic [SZ_W-1:0]  granLog;

  always_comb begin
    accBytes = (OFF_W+1)'(1) << reqSize;
    sizeMask = OFF_W'(accBytes - 1'b1);
    aligned  = (reqOffset & sizeMask) == '0;

    diMode  = 1'b1;
    granLog = '0;
    case (reqMode)
      MODE_BE_DI16: granLog = SZ_W'(1);
      MODE_BE_DI32: granLog = SZ_W'(2);
      MODE_BE_DI64: granLog = SZ_W'(3);
      default:      diMode  = 1'b0;
    endcase
    gBytes = (OFF_W+1)'(1) << granLog;

    ctrl          = '0;
    ctrl.fire     = reqValid;
    ctrl.isStore  = reqStore;
    ctrl.misalign = !aligned;
    ctrl.reverse  = (reqMode == MODE_BE_ADDR);
    ctrl.lastIdx  = sizeMask;
    if (diMode && (accBytes < gBytes))
      ctrl.physOff = reqOffset ^ OFF_W'(gBytes - accBytes);
    else
      ctrl.physOff = reqOffset;
    for (int i = 0; i < LANES; i++)
      ctrl.keep[i] = (i < int'(accBytes));
    ctrl.laneEn = aligned ? (ctrl.keep << ctrl.physOff) : '0;
  end
endmodule

// File: rtl/steer_datapath.sv
module steer_datapath
  import lane_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  steer_ctrl_t      ctrl,
  input  logic [DW-1:0]    memRdata,
  input  logic [DW-1:0]    stData,
  output logic             rspValid,
  output logic             rspErr,
  output logic [DW-1:0]    ldData,
  output logic [DW-1:0]    wrData,
  output logic [LANES-1:0] wrBe
);
  logic [DW-1:0]    shifted;
  logic [DW-1:0]    ldNext;
  logic [DW-1:0]    stVal;
  logic [DW-1:0]    wrNext;
  logic [OFF_W-1:0] src;

  always_comb begin
    shifted = memRdata >> {ctrl.physOff, 3'b000};
    ldNext  = '0;
    stVal   = '0;
    src     = '0;
    for (int i = 0; i < LANES; i++) begin
      src = ctrl.reverse ? OFF_W'(ctrl.lastIdx - OFF_W'(i)) : OFF_W'(i);
      if (ctrl.keep[i]) begin
        ldNext[i*8 +: 8] = shifted[{src, 3'b000} +: 8];
        stVal[i*8 +: 8]  = stData[{src, 3'b000} +: 8];
      end
    end
    wrNext = stVal << {ctrl.physOff, 3'b000};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      ldData   <= '0;
      wrData   <= '0;
      wrBe     <= '0;
    end else begin
      rspValid <= ctrl.fire;
      if (ctrl.fire) begin
        rspErr <= ctrl.misalign;
        ldData <= (!ctrl.isStore && !ctrl.misalign) ? ldNext : '0;
        wrData <= (ctrl.isStore && !ctrl.misalign) ? wrNext : '0;
        wrBe   <= ctrl.isStore ? ctrl.laneEn : '0;
      end
    end
  end

  // R7: an error response carries no data and no enables
  p_err_clears_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspErr) |-> (wrBe == '0 && ldData == '0 && wrData == '0));
endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import lane_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reqStore,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [SZ_W-1:0]  reqSize,
  input  logic [2:0]       reqMode,
  input  logic [DW-1:0]    memRdata,
  input  logic [DW-1:0]    stData,
  output logic             rspValid,
  output logic             rspErr,
  output logic [DW-1:0]    ldData,
  output logic [DW-1:0]    wrData,
  output logic [LANES-1:0] wrBe
);
  steer_ctrl_t ctrlBus;

  steer_ctrl i_ctrl (
    .reqValid (reqValid),
    .reqStore (reqStore),
    .reqOffset(reqOffset),
    .reqSize  (reqSize),
    .reqMode  (reqMode),
    .ctrl     (ctrlBus)
  );

  steer_datapath i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrlBus),
    .memRdata(memRdata),
    .stData  (stData),
    .rspValid(rspValid),
    .rspErr  (rspErr),
    .ldData  (ldData),
    .wrData  (wrData),
    .wrBe    (wrBe)
  );

  // R8: a response only follows a request
  p_resp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> $past(reqValid));

  // R6: an aligned store enables exactly S lanes
  p_store_be_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspErr && $past(reqStore)) |->
      ($countones(wrBe) == (1 << $past(reqSize))));

  // R6: loads never raise byte enables
  p_load_no_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !$past(reqStore)) |-> (wrBe == '0));

  // R1: a single-byte load is zero-extended
  p_byte_load_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !$past(reqStore) && $past(reqSize) == '0) |->
      (ldData[DW-1:8] == '0));
endmodule

// File: tb/test_lane_steer.sv
`timescale 1ns/1ps
module test_lane_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqStore = 1'b0;
  logic [2:0]  reqOffset = '0;
  logic [1:0]  reqSize = '0;
  logic [2:0]  reqMode = '0;
  logic [63:0] memRdata = '0;
  logic [63:0] stData = '0;
  logic        rspValid;
  logic        rspErr;
  logic [63:0] ldData;
  logic [63:0] wrData;
  logic [7:0]  wrBe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lane_steer i_lane_steer (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqStore(reqStore),
    .reqOffset(reqOffset), .reqSize(reqSize), .reqMode(reqMode),
    .memRdata(memRdata), .stData(stData), .rspValid(rspValid),
    .rspErr(rspErr), .ldData(ldData), .wrData(wrData), .wrBe(wrBe)
  );

  task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic int granOf(int mode);
    if (mode == 2) return 2;
    if (mode == 3) return 4;
    if (mode == 4) return 8;
    return 0;
  endfunction

  // memory address of value byte i
  function automatic int addrOf(int mode, int a, int s, int i);
    int g;
    g = granOf(mode);
    if (mode == 1) return a + s - 1 - i;
    if (g != 0 && s < g) return (a - (a % g)) + (g - (a % g) - s) + i;
    return a + i;
  endfunction

  function automatic string tagOf(int mode, bit st, int s, bit mis);
    if (mis) return "R7";
    if (st) return "R5";
    if (mode == 0) return "R1";
    if (mode == 1) return "R2";
    if (mode >= 5) return "R10";
    if (s >= granOf(mode)) return "R3";
    return "R4";
  endfunction

  task automatic access(int mode, bit st, int off, int szc,
                        logic [63:0] mem, logic [63:0] sd);
    int s;
    bit mis;
    logic [63:0] eLd, eWr;
    logic [7:0] eBe;
    string rq;
    s = 1 << szc;
    mis = (off % s) != 0;
    eLd = '0; eWr = '0; eBe = '0;
    if (!mis) begin
      for (int i = 0; i < s; i++) begin
        int ad;
        ad = addrOf(mode, off, s, i);
        if (st) begin
          eWr[ad*8 +: 8] = sd[i*8 +: 8];
          eBe[ad] = 1'b1;
        end else begin
          eLd[i*8 +: 8] = mem[ad*8 +: 8];
        end
      end
    end
    rq = tagOf(mode, st, s, mis);
    @(negedge clk);
    reqValid = 1'b1; reqStore = st; reqOffset = 3'(off);
    reqSize = 2'(szc); reqMode = 3'(mode); memRdata = mem; stData = sd;
    @(negedge clk);
    check("R8", "rspValid", 64'(rspValid), 64'd1);
    check(rq, "rspErr", 64'(rspErr), 64'(mis));
    check(rq, "ldData", ldData, eLd);
    check(st ? rq : "R5", "wrData", wrData, eWr);
    check(mis ? "R7" : "R6", "wrBe", 64'(wrBe), 64'(eBe));
  endtask

  task automatic loadConst(string rq, int mode, int off, int szc,
                           logic [63:0] mem, logic [63:0] exp);
    @(negedge clk);
    reqValid = 1'b1; reqStore = 1'b0; reqOffset = 3'(off);
    reqSize = 2'(szc); reqMode = 3'(mode); memRdata = mem; stData = '0;
    @(negedge clk);
    check(rq, "directed ldData", ldData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] mems [2];
    logic [63:0] sds [2];
    int modes [6];
    mems[0] = 64'h99887766ddccbbaa; mems[1] = 64'h0123456789abcdef;
    sds[0]  = 64'hf0e1d2c3b4a59687; sds[1]  = 64'h1122334455667788;
    modes[0] = 0; modes[1] = 1; modes[2] = 2;
    modes[3] = 3; modes[4] = 4; modes[5] = 6;

    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "rspValid", 64'(rspValid), 64'd0);
    check("R9", "rspErr", 64'(rspErr), 64'd0);
    check("R9", "ldData", ldData, 64'd0);
    check("R9", "wrData", wrData, 64'd0);
    check("R9", "wrBe", 64'(wrBe), 64'd0);
    rst_n = 1'b1;

    // directed cases from the requirements
    loadConst("R1", 0, 0, 2, mems[0], 64'hddccbbaa);
    loadConst("R2", 1, 0, 2, mems[0], 64'haabbccdd);
    loadConst("R2", 1, 0, 0, mems[0], 64'haa);
    loadConst("R4", 3, 0, 0, mems[0], 64'hdd);
    loadConst("R4", 3, 0, 1, mems[0], 64'hddcc);
    loadConst("R4", 2, 0, 0, mems[0], 64'hbb);
    loadConst("R4", 4, 0, 2, mems[0], 64'h99887766);
    loadConst("R3", 2, 0, 2, mems[0], 64'hddccbbaa);
    loadConst("R3", 4, 0, 3, mems[0], 64'h99887766ddccbbaa);
    loadConst("R10", 7, 0, 1, mems[0], 64'hbbaa);

    // R8: idle cycle keeps data, drops valid
    @(negedge clk);
    reqValid = 1'b0; reqMode = 3'd1; memRdata = 64'hffffffffffffffff;
    @(negedge clk);
    check("R8", "idle rspValid", 64'(rspValid), 64'd0);
    check("R8", "idle ldData hold", ldData, 64'hbbaa);

    // exhaustive sweep, modes change every access (R8)
    for (int p = 0; p < 2; p++)
      for (int st = 0; st < 2; st++)
        for (int sz = 0; sz < 4; sz++)
          for (int off = 0; off < 8; off++)
            for (int m = 0; m < 6; m++)
              access(modes[m], st[0], off, sz, mems[p], sds[p]);

    @(negedge clk);
    reqValid = 1'b0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule